// File: doc/BRIEF.md
# Multiplexed GPIO port controller

This block owns the pin assignment of a chip's general-purpose I/O: twelve ports of sixteen pins each. Software programs a bank of 16-bit registers over a simple register bus, one bit per pin. The registers decide, pin by pin, whether the pad is plain software-controlled I/O or is handed to one of eight peripheral function slots. They also set who drives the output enable, whether the input path is live, and whether a driven output can be read back.

Each pin has a pad-facing side (`pad_out`, `pad_oe`, `pad_in`) and a peripheral-facing side of eight slots (`fn_dout`, `fn_oe`, `fn_din`). The slot routing and output-enable selection are combinational. The software-visible pin level passes through a two-flop synchroniser and is masked by the read-enable rules.

Top module: `pmux_port_ctrl`

## Requirements
- R1: A register of port p (0..11) sits at byte address base + 4*p, with bases 0x0000 output data, 0x0200 pin level, 0x0300 direction, 0x0400 mode, 0x0500/0x0600/0x0A00 function select bits 0/1/2, 0x4000 input enable, 0x4100 bidirectional enable, 0x4200 peripheral-direction enable. Any other address (misaligned, port 12 or above, unknown base) reads 0, and a write to it changes nothing.
- R2: After reset every direction register reads 0xFFFF and every other register reads 0x0000.
- R3: With mode bit 0 (port mode), the pad output is the output-data bit and the pad output enable is the inverse of the direction bit (direction 1 = input).
- R4: With mode bit 1 (alternate mode), the slot index is {select bit2, bit1, bit0}, and the pad output is `fn_dout[pin*8 + index]`.
- R5: In alternate mode with peripheral-direction bit 1, the pad output enable is `fn_oe[pin*8 + index]`; with that bit 0, and in port mode, it is the inverse of the direction bit.
- R6: The pin-level register returns, for each bit, the pad input delayed by two clock edges, and only where input enable is 1 and either direction is 1 or bidirectional enable is 1; all other bits read 0.
- R7: The pin-level register is read-only; writing to it leaves all state and all outputs unchanged.
- R8: In alternate mode `fn_din[pin*8 + index]` carries the pad input without delay; every other slot bit of that pin, and all slots of a port-mode pin, are 0.
- R9: Every writable register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address (read and write) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pad_out | output | 192 | Value driven toward each pad |
| pad_oe | output | 192 | Output enable of each pad |
| pad_in | input | 192 | Level sensed at each pad |
| fn_dout | input | 1536 | Peripheral output data, bit pin*8+slot |
| fn_oe | input | 1536 | Peripheral output enable, bit pin*8+slot |
| fn_din | output | 1536 | Pad level delivered to the selected slot, bit pin*8+slot |

## Verification
A corrupted configuration bit surfaces at the pads in the same cycle it is stored: the wrong slot's data or enable appears on `pad_out`/`pad_oe` and the wrong `fn_din` bit toggles. A register-file fault is also visible on the very next read of that address. A synchroniser or masking fault shows only on reads of the pin-level register, two edges after a pad change. The bench therefore compares every output and the current read data against a behavioural model on each clock while sweeping random pad, peripheral and register traffic.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

    localparam int unsigned REG_W    = 16;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned FN_COUNT = 8;
    localparam int unsigned FSEL_W   = $clog2(FN_COUNT);

    typedef enum logic [3:0] {
        K_NONE, K_DOUT, K_LEVEL, K_DIR, K_MODE,
        K_FS0, K_FS1, K_FS2, K_IBE, K_BIDIR, K_PDC
    } reg_kind_e;

    // one bit per pin in every plane
    typedef struct packed {
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] fs0;
        logic [REG_W-1:0] fs1;
        logic [REG_W-1:0] fs2;
        logic [REG_W-1:0] ibe;
        logic [REG_W-1:0] bidir;
        logic [REG_W-1:0] pdc;
    } port_cfg_t;

    typedef struct packed {
        reg_kind_e  kind;
        logic [5:0] port;
    } reg_sel_t;

    function automatic reg_kind_e kind_of(input logic [7:0] page);
        case (page)
            8'h00:   return K_DOUT;
            8'h02:   return K_LEVEL;
            8'h03:   return K_DIR;
            8'h04:   return K_MODE;
            8'h05:   return K_FS0;
            8'h06:   return K_FS1;
            8'h0A:   return K_FS2;
            8'h40:   return K_IBE;
            8'h41:   return K_BIDIR;
            8'h42:   return K_PDC;
            default: return K_NONE;
        endcase
    endfunction

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] addr,
                                        input int unsigned nports);
        reg_sel_t s;
        s.kind = kind_of(addr[15:8]);
        s.port = addr[7:2];
        if (addr[1:0] != 2'b00 || 32'(addr[7:2]) >= nports)
            s.kind = K_NONE;
        return s;
    endfunction

    function automatic port_cfg_t cfg_reset();
        port_cfg_t c;
        c     = '0;
        c.dir = '1;
        return c;
    endfunction

endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
    parameter int unsigned W = 192
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (rst)
        q == $past(stage1)); // R6

endmodule

// File: rtl/pmux_regs.sv
module pmux_regs
    import pmux_pkg::*;
#(
    parameter int unsigned NPORTS = 12,
    localparam int unsigned PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    input  logic [NPORTS*REG_W-1:0]  pin_level,
    output port_cfg_t [NPORTS-1:0]   cfg,
    output logic [REG_W-1:0]         rdata
);
    reg_sel_t        sel;
    logic [PW-1:0]   idx;
    port_cfg_t [NPORTS-1:0] cfg_q;

    assign sel = decode(addr, NPORTS);
    assign idx = sel.port[PW-1:0];
    assign cfg = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < int'(NPORTS); p++)
                cfg_q[p] <= cfg_reset();
        end else if (we) begin
            case (sel.kind)
                K_DOUT:  cfg_q[idx].dout  <= wdata;
                K_DIR:   cfg_q[idx].dir   <= wdata;
                K_MODE:  cfg_q[idx].mode  <= wdata;
                K_FS0:   cfg_q[idx].fs0   <= wdata;
                K_FS1:   cfg_q[idx].fs1   <= wdata;
                K_FS2:   cfg_q[idx].fs2   <= wdata;
                K_IBE:   cfg_q[idx].ibe   <= wdata;
                K_BIDIR: cfg_q[idx].bidir <= wdata;
                K_PDC:   cfg_q[idx].pdc   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel.kind)
            K_DOUT:  rdata = cfg_q[idx].dout;
            K_LEVEL: rdata = pin_level[int'(idx)*REG_W +: REG_W];
            K_DIR:   rdata = cfg_q[idx].dir;
            K_MODE:  rdata = cfg_q[idx].mode;
            K_FS0:   rdata = cfg_q[idx].fs0;
            K_FS1:   rdata = cfg_q[idx].fs1;
            K_FS2:   rdata = cfg_q[idx].fs2;
            K_IBE:   rdata = cfg_q[idx].ibe;
            K_BIDIR: rdata = cfg_q[idx].bidir;
            K_PDC:   rdata = cfg_q[idx].pdc;
            default: rdata = '0;
        endcase
    end

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && sel.kind == K_NONE) |=> $stable(cfg_q)); // R1

    AST_LEVEL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && sel.kind == K_LEVEL) |=> $stable(cfg_q)); // R7

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q[NPORTS-1].dir == '1 && cfg_q[0].mode == '0
                        && cfg_q[0].ibe == '0)); // R2

endmodule

// File: rtl/pmux_pin.sv
module pmux_pin
    import pmux_pkg::*;
#(
    parameter int unsigned NFUNC = FN_COUNT,
    localparam int unsigned SW   = $clog2(NFUNC)
) (
    input  logic             dout,
    input  logic             dir,
    input  logic             alt,
    input  logic             pdc,
    input  logic [SW-1:0]    fsel,
    input  logic [NFUNC-1:0] fn_dout,
    input  logic [NFUNC-1:0] fn_oe,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic [NFUNC-1:0] fn_din
);
    always_comb begin
        fn_din = '0;
        if (alt) begin
            pad_out      = fn_dout[fsel];
            pad_oe       = pdc ? fn_oe[fsel] : ~dir;
            fn_din[fsel] = pad_in;
        end else begin
            pad_out = dout;
            pad_oe  = ~dir;
        end
    end

endmodule

// File: rtl/pmux_port_ctrl.sv
module pmux_port_ctrl
    import pmux_pkg::*;
#(
    parameter int unsigned  NPORTS = 12,
    localparam int unsigned NPINS  = NPORTS * REG_W,
    localparam int unsigned PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    output logic [NPINS-1:0]          pad_out,
    output logic [NPINS-1:0]          pad_oe,
    input  logic [NPINS-1:0]          pad_in,
    input  logic [NPINS*FN_COUNT-1:0] fn_dout,
    input  logic [NPINS*FN_COUNT-1:0] fn_oe,
    output logic [NPINS*FN_COUNT-1:0] fn_din
);
    port_cfg_t [NPORTS-1:0] cfg;
    logic [NPINS-1:0]       lvl_sync;
    logic [NPINS-1:0]       pin_level;
    reg_sel_t               rsel;

    pmux_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl_sync)
    );

    pmux_regs #(.NPORTS(NPORTS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pin_level (pin_level),
        .cfg       (cfg),
        .rdata     (reg_rdata)
    );

    for (genvar p = 0; p < int'(NPORTS); p++) begin : g_port
        // readable when the buffer is on and the pin is an input or loops back
        assign pin_level[p*REG_W +: REG_W] = lvl_sync[p*REG_W +: REG_W] & cfg[p].ibe
                                             & (cfg[p].dir | cfg[p].bidir);

        for (genvar b = 0; b < int'(REG_W); b++) begin : g_pin
            localparam int unsigned PIN = p * REG_W + b;

            pmux_pin #(.NFUNC(FN_COUNT)) u_pin (
                .dout    (cfg[p].dout[b]),
                .dir     (cfg[p].dir[b]),
                .alt     (cfg[p].mode[b]),
                .pdc     (cfg[p].pdc[b]),
                .fsel    ({cfg[p].fs2[b], cfg[p].fs1[b], cfg[p].fs0[b]}),
                .fn_dout (fn_dout[PIN*FN_COUNT +: FN_COUNT]),
                .fn_oe   (fn_oe[PIN*FN_COUNT +: FN_COUNT]),
                .pad_in  (pad_in[PIN]),
                .pad_out (pad_out[PIN]),
                .pad_oe  (pad_oe[PIN]),
                .fn_din  (fn_din[PIN*FN_COUNT +: FN_COUNT])
            );

            AST_OE_FROM_DIRECTION: assert property (@(posedge clk) disable iff (rst)
                !(cfg[p].mode[b] && cfg[p].pdc[b]) |-> (pad_oe[PIN] == !cfg[p].dir[b])); // R5

            AST_ONE_SLOT_FED: assert property (@(posedge clk) disable iff (rst)
                $onehot0(fn_din[PIN*FN_COUNT +: FN_COUNT])); // R8
        end
    end

    assign rsel = decode(reg_addr, NPORTS);

    AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rsel.kind == K_LEVEL) |->
        ((reg_rdata & ~cfg[rsel.port[PW-1:0]].ibe) == '0)); // R6

endmodule

// File: tb/sim_pmux_port_ctrl.sv
module sim_pmux_port_ctrl;

    localparam int NP   = 12;
    localparam int NPIN = NP * 16;
    localparam int NF   = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 reg_we = 1'b0;
    logic [15:0]          reg_addr = '0;
    logic [15:0]          reg_wdata = '0;
    logic [15:0]          reg_rdata;
    logic [NPIN-1:0]      pad_out, pad_oe;
    logic [NPIN-1:0]      pad_in = '0;
    logic [NPIN*NF-1:0]   fn_dout = '0, fn_oe = '0;
    logic [NPIN*NF-1:0]   fn_din;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pmux_port_ctrl u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
        .fn_dout(fn_dout), .fn_oe(fn_oe), .fn_din(fn_din)
    );

    // model planes: 0 data,1 level,2 dir,3 mode,4 sel0,5 sel1,6 sel2,7 ibe,8 bidir,9 pdc
    logic [15:0]     m_reg [10][NP];
    logic [NPIN-1:0] m_s1, m_s2;

    function automatic int bkind(input logic [15:0] a);
        int k;
        case (a[15:8])
            8'h00: k = 0;  8'h02: k = 1;  8'h03: k = 2;  8'h04: k = 3;
            8'h05: k = 4;  8'h06: k = 5;  8'h0A: k = 6;  8'h40: k = 7;
            8'h41: k = 8;  8'h42: k = 9;  default: k = -1;
        endcase
        if (a[1:0] != 2'b00 || int'(a[7:2]) >= NP) k = -1;
        return k;
    endfunction

    function automatic logic [15:0] base_of(input int k);
        case (k)
            0: return 16'h0000; 1: return 16'h0200; 2: return 16'h0300;
            3: return 16'h0400; 4: return 16'h0500; 5: return 16'h0600;
            6: return 16'h0A00; 7: return 16'h4000; 8: return 16'h4100;
            default: return 16'h4200;
        endcase
    endfunction

    always @(posedge clk) begin
        int k;
        if (rst) begin
            for (int i = 0; i < 10; i++)
                for (int p = 0; p < NP; p++)
                    m_reg[i][p] <= (i == 2) ? 16'hFFFF : 16'h0000;
            m_s1 <= '0;
            m_s2 <= '0;
        end else begin
            k = bkind(reg_addr);
            if (reg_we && k >= 0 && k != 1)
                m_reg[k][int'(reg_addr[7:2])] <= reg_wdata;
            m_s1 <= pad_in;
            m_s2 <= m_s1;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        logic [NPIN-1:0]    e_out, e_oe;
        logic [NPIN*NF-1:0] e_din;
        logic [15:0]        e_rd;
        int k, pt;
        if (!rst && !done) begin
            for (int p = 0; p < NPIN; p++) begin
                int q, b, f;
                logic alt;
                q   = p / 16;
                b   = p % 16;
                alt = m_reg[3][q][b];
                f   = int'({m_reg[6][q][b], m_reg[5][q][b], m_reg[4][q][b]});
                e_out[p] = alt ? fn_dout[p*NF + f] : m_reg[0][q][b];
                e_oe[p]  = (alt && m_reg[9][q][b]) ? fn_oe[p*NF + f] : !m_reg[2][q][b];
                for (int s = 0; s < NF; s++)
                    e_din[p*NF + s] = (alt && s == f) ? pad_in[p] : 1'b0;
            end
            k = bkind(reg_addr);
            pt = int'(reg_addr[7:2]);
            if (k < 0) e_rd = '0;
            else if (k == 1) begin
                for (int b = 0; b < 16; b++)
                    e_rd[b] = m_s2[pt*16 + b] & m_reg[7][pt][b]
                              & (m_reg[2][pt][b] | m_reg[8][pt][b]);
            end else e_rd = m_reg[k][pt];

            n_chk += 4;
            if (pad_out !== e_out) begin
                n_bad++;
                $display("FAIL R3 R4 pad_out: got %h expected %h", pad_out, e_out);
            end
            if (pad_oe !== e_oe) begin
                n_bad++;
                $display("FAIL R3 R5 pad_oe: got %h expected %h", pad_oe, e_oe);
            end
            if (fn_din !== e_din) begin
                n_bad++;
                $display("FAIL R8 fn_din: got %h expected %h", fn_din, e_din);
            end
            if (reg_rdata !== e_rd) begin
                n_bad++;
                $display("FAIL R1 R6 R9 rdata @%h: got %h expected %h", reg_addr, reg_rdata, e_rd);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rdv(input string req, input logic [15:0] a, input logic [15:0] exp);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk); #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] slice;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R2 reset state
        rdv("R2 dir port0",   16'h0300, 16'hFFFF);
        rdv("R2 dir port11",  16'h032C, 16'hFFFF);
        rdv("R2 mode port4",  16'h0410, 16'h0000);
        rdv("R2 pdc port11",  16'h422C, 16'h0000);

        // R9 read-back
        wr(16'h0414, 16'hA5C3);
        rdv("R9 mode port5",  16'h0414, 16'hA5C3);
        wr(16'h0A14, 16'h1234);
        rdv("R9 sel2 port5",  16'h0A14, 16'h1234);
        wr(16'h0414, 16'h0000);
        wr(16'h0A14, 16'h0000);

        // R1 unmapped addresses
        wr(16'h0030, 16'hFFFF);
        rdv("R1 port12 reads 0",  16'h0030, 16'h0000);
        rdv("R1 port11 untouched", 16'h002C, 16'h0000);
        wr(16'h0102, 16'hFFFF);
        rdv("R1 unknown base",    16'h0102, 16'h0000);
        wr(16'h0001, 16'hFFFF);
        rdv("R1 misaligned",      16'h0001, 16'h0000);
        rdv("R1 port0 data untouched", 16'h0000, 16'h0000);

        // R3 port mode on port 3
        wr(16'h000C, 16'h00F0);
        wr(16'h030C, 16'h0F0F);
        settle();
        chk("R3 pad_out port3", 32'(pad_out[63:48]), 32'h00F0);
        chk("R3 pad_oe port3",  32'(pad_oe[63:48]),  32'hF0F0);

        // R4 alternate mode on port 7, slot index = pin % 8
        wr(16'h041C, 16'hFFFF);
        wr(16'h051C, 16'hAAAA);
        wr(16'h061C, 16'hCCCC);
        wr(16'h0A1C, 16'hF0F0);
        @(posedge clk); #2;
        fn_dout = '1;
        for (int b = 0; b < 16; b++) fn_dout[(112 + b)*NF + (b % 8)] = 1'b0;
        settle();
        chk("R4 selected slot low", 32'(pad_out[127:112]), 32'h0000);
        @(posedge clk); #2;
        fn_dout = '0;
        for (int b = 0; b < 16; b++) fn_dout[(112 + b)*NF + (b % 8)] = 1'b1;
        settle();
        chk("R4 selected slot high", 32'(pad_out[127:112]), 32'hFFFF);

        // R5 direction ownership
        wr(16'h421C, 16'h00FF);
        wr(16'h031C, 16'h5555);
        @(posedge clk); #2;
        fn_oe = '0;
        settle();
        chk("R5 oe slots off", 32'(pad_oe[127:112]), 32'hAA00);
        @(posedge clk); #2;
        fn_oe = '1;
        settle();
        chk("R5 oe slots on",  32'(pad_oe[127:112]), 32'hAAFF);

        // R8 peripheral input
        @(posedge clk); #2;
        pad_in[115] = 1'b1;
        pad_in[51]  = 1'b1;
        settle();
        slice = fn_din[115*NF +: NF];
        chk("R8 slot 3 fed", 32'(slice), 32'h08);
        slice = fn_din[51*NF +: NF];
        chk("R8 port-mode pin no slot", 32'(slice), 32'h00);

        // R6 level read with masking and latency on port 2
        @(posedge clk); #2;
        pad_in[47:32] = 16'hBEEF;
        repeat (3) @(posedge clk);
        rdv("R6 buffer off", 16'h0208, 16'h0000);
        wr(16'h4008, 16'hFFFF);
        rdv("R6 inputs",     16'h0208, 16'hBEEF);
        wr(16'h0308, 16'h00FF);
        rdv("R6 outputs without loopback", 16'h0208, 16'h00EF);
        wr(16'h4108, 16'hFF00);
        rdv("R6 outputs with loopback",    16'h0208, 16'hBEEF);
        @(posedge clk); #2;
        pad_in[47:32] = 16'h1234;
        @(negedge clk); #1;
        chk("R6 edge0 old", 32'(reg_rdata), 32'hBEEF);
        @(negedge clk); #1;
        chk("R6 edge1 old", 32'(reg_rdata), 32'hBEEF);
        @(negedge clk); #1;
        chk("R6 edge2 new", 32'(reg_rdata), 32'h1234);

        // R7 level register is read-only
        wr(16'h0208, 16'h0000);
        rdv("R7 level after write", 16'h0208, 16'h1234);
        rdv("R7 data reg untouched", 16'h0008, 16'h0000);

        // random sweep checked each clock by the model comparison
        for (int c = 0; c < 600; c++) begin
            @(posedge clk); #2;
            for (int w = 0; w < NPIN/32; w++) pad_in[w*32 +: 32] = $urandom;
            if (c % 4 == 0) begin
                for (int w = 0; w < NPIN*NF/32; w++) begin
                    fn_dout[w*32 +: 32] = $urandom;
                    fn_oe[w*32 +: 32]   = $urandom;
                end
            end
            reg_we    = ($urandom % 3) != 0;
            reg_wdata = 16'($urandom);
            if ($urandom % 8 == 0) reg_addr = 16'($urandom);
            else reg_addr = base_of(int'($urandom % 10)) | 16'(4 * ($urandom % NP));
        end
        @(posedge clk); #2;
        reg_we = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule